// File: doc/BRIEF.md
# Infrared SIR Transmit Framer

This block turns a stream of payload bytes into a complete slow-infrared link-layer frame, ready for a byte-wide asynchronous serializer. On a start request it emits the start-flag preamble, then passes the payload (address, control and information bytes) through, escaping any byte that could be mistaken for a flag. It then appends a 16-bit frame check sequence over the payload and closes the frame with a stop flag. Both byte interfaces use valid/ready handshakes, and the framer holds its state whenever the serializer stalls.

A frame is requested by holding `sof_req` while the block is idle. The flag count and the pattern selector are captured in that cycle. The upstream source then offers payload bytes and marks the final one with `in_last`. The framer walks through the states `S_IDLE`, `S_PREAMBLE` (extra flags), `S_START` (closing 0xC0 flag), `S_PAYLOAD`, `S_CRC_LO`, `S_CRC_HI` and `S_STOP`. The transitions are:
- IDLE→PREAMBLE when the request asks for more than one flag, or IDLE→START when it asks for one flag.
- PREAMBLE→START once the last extra flag is accepted.
- START→PAYLOAD when the flag is accepted.
- PAYLOAD→CRC_LO when the byte marked last is accepted.
- CRC_LO→CRC_HI, then CRC_HI→STOP, on acceptance.
- STOP→IDLE when the stop flag is accepted.

Top module: `sir_tx_framer`

## Requirements
- R1: While reset is active and after it is released, `out_valid`, `in_ready`, `busy` and `frame_done` are 0 until a frame is requested.
- R2: A frame opens with N flag bytes, where N is the captured `flag_cnt` (0 counts as 1). The last of them is 0xC0. The N-1 bytes before it are 0xC0 when `extra_ff` is 0 and 0xFF when `extra_ff` is 1.
- R3: The payload bytes appear in input order after the flags. A byte equal to 0xC0, 0xC1 or 0x7D is sent as 0x7D followed by the byte XOR 0x20. Other bytes are sent unchanged.
- R4: After the payload come two check bytes. They are the ones' complement of a CRC-16 with reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset 0xFFFF and processed LSB first, taken over the unescaped payload bytes only. The low byte is sent first. The payload "123456789" yields 0x6E then 0x90.
- R5: A check byte equal to 0xC0, 0xC1 or 0x7D is escaped by the same rule as R3. Flag bytes are never escaped.
- R6: The frame ends with one 0xC1 byte. `frame_done` is high in exactly the cycle that byte is accepted, and `busy` is 0 in the following cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. No byte is lost or repeated under any stall pattern.
- R8: A request accepted in the cycle right after `frame_done` gets at least two flags. A captured count of 0 or 1 becomes 2, with the extra flag following `extra_ff`.
- R9: `in_ready` is 1 only during the payload phase. `sof_req`, `flag_cnt` and `extra_ff` have no effect on the frame in progress after the start request is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_req | input | 1 | Start-of-frame request, taken when idle |
| flag_cnt | input | CNT_W | Number of start flags (0 means 1) |
| extra_ff | input | 1 | 1: extra start flags are 0xFF, 0: 0xC0 |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| out_data | output | 8 | Framed byte to serializer |
| out_valid | output | 1 | Framed byte valid |
| out_ready | input | 1 | Serializer accepts a byte |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | Stop flag accepted this cycle |

## Verification
The assertions assume that the source keeps `in_data` and `in_last` steady while `in_valid` is high and `in_ready` is low, since the escape stage re-reads the held byte in its second phase. They also assume every frame carries at least one payload byte. The bench holds each offered byte until it sees `in_ready` at the sampling point, and it draws every frame length from one upward. Random serializer stalls, random source bubbles, payloads biased toward the three reserved values, and configuration changes while a frame is running stay inside these assumptions. Back-to-back requests are issued in the cycle after `frame_done`.

// File: rtl/sir_pkg.sv
package sir_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] FLAG_OPEN  = 8'hC0;
    localparam logic [BYTE_W-1:0] FLAG_FILL  = 8'hFF;
    localparam logic [BYTE_W-1:0] FLAG_CLOSE = 8'hC1;
    localparam logic [BYTE_W-1:0] ESC_CHAR   = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_FLIP   = 8'h20;

    localparam logic [15:0] FCS_PRESET = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_START,
        S_PAYLOAD,
        S_CRC_LO,
        S_CRC_HI,
        S_STOP
    } sir_state_e;

    function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
        return (b == FLAG_OPEN) || (b == FLAG_CLOSE) || (b == ESC_CHAR);
    endfunction

    function automatic logic [15:0] fcs_byte(input logic [15:0] cur,
                                             input logic [BYTE_W-1:0] d);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[0] ^ d[i];
            r  = (r >> 1) ^ (fb ? FCS_POLY_R : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/sir_fcs16.sv
module sir_fcs16
    import sir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       fcs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcs <= FCS_PRESET;
        end else if (clear) begin
            fcs <= FCS_PRESET;
        end else if (update) begin
            fcs <= fcs_byte(fcs, din);
        end
    end

endmodule

// File: rtl/sir_escaper.sv
module sir_escaper
    import sir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] raw_data,
    input  logic              raw_valid,
    input  logic              raw_esc_en,
    output logic              raw_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    logic second_half;
    logic needs_esc;
    logic out_fire;

    assign needs_esc = raw_esc_en && is_reserved(raw_data);
    assign out_fire  = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second_half <= 1'b0;
        end else if (out_fire) begin
            if (second_half) begin
                second_half <= 1'b0;
            end else if (needs_esc) begin
                second_half <= 1'b1;
            end
        end
    end

    always_comb begin
        out_valid = raw_valid;
        if (second_half) begin
            out_data  = raw_data ^ ESC_FLIP;
            raw_ready = out_ready;
        end else if (needs_esc) begin
            out_data  = ESC_CHAR;
            raw_ready = 1'b0;
        end else begin
            out_data  = raw_data;
            raw_ready = out_ready;
        end
    end

    // R3: the byte behind a pending escape must still be offered unchanged
    assert_escape_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && !$rose(second_half)) |-> (raw_valid && $stable(raw_data)));

    // R5: the second half of an escape is never itself a reserved value
    assert_escape_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && out_valid) |-> !is_reserved(out_data));

endmodule

// File: rtl/sir_tx_framer.sv
module sir_tx_framer
    import sir_pkg::*;
#(
    parameter int CNT_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_req,
    input  logic [CNT_W-1:0]  flag_cnt,
    input  logic              extra_ff,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              busy,
    output logic              frame_done
);

    localparam logic [CNT_W-1:0] ONE_FLAG    = CNT_W'(1);
    localparam logic [CNT_W-1:0] B2B_MINIMUM = CNT_W'(2);

    sir_state_e        state, state_nx;
    logic [CNT_W-1:0]  fill_left;
    logic [CNT_W-1:0]  req_flags;
    logic              fill_ff;
    logic              just_ended;

    logic [BYTE_W-1:0] raw_data;
    logic              raw_valid;
    logic              raw_esc_en;
    logic              raw_ready;
    logic              fire;
    logic [15:0]       fcs;

    assign fire = raw_valid && raw_ready;

    // Effective flag count for a request taken this cycle
    always_comb begin
        req_flags = (flag_cnt == '0) ? ONE_FLAG : flag_cnt;
        if (just_ended && (req_flags < B2B_MINIMUM)) begin
            req_flags = B2B_MINIMUM;
        end
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (sof_req) begin
                    state_nx = (req_flags > ONE_FLAG) ? S_PREAMBLE : S_START;
                end
            end
            S_PREAMBLE: begin
                if (fire && (fill_left == ONE_FLAG)) begin
                    state_nx = S_START;
                end
            end
            S_START: begin
                if (fire) state_nx = S_PAYLOAD;
            end
            S_PAYLOAD: begin
                if (fire && in_last) state_nx = S_CRC_LO;
            end
            S_CRC_LO: begin
                if (fire) state_nx = S_CRC_HI;
            end
            S_CRC_HI: begin
                if (fire) state_nx = S_STOP;
            end
            S_STOP: begin
                if (fire) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register and per-frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            fill_left  <= '0;
            fill_ff    <= 1'b0;
            just_ended <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && sof_req) begin
                fill_left <= req_flags - ONE_FLAG;
                fill_ff   <= extra_ff;
            end else if (state == S_PREAMBLE && fire) begin
                fill_left <= fill_left - ONE_FLAG;
            end
            if (state == S_STOP && fire) begin
                just_ended <= 1'b1;
            end else if (state == S_IDLE) begin
                just_ended <= 1'b0;
            end
        end
    end

    // Byte source selection per state
    always_comb begin
        raw_data   = FLAG_OPEN;
        raw_valid  = 1'b0;
        raw_esc_en = 1'b0;
        unique case (state)
            S_IDLE: begin
                raw_valid = 1'b0;
            end
            S_PREAMBLE: begin
                raw_data  = fill_ff ? FLAG_FILL : FLAG_OPEN;
                raw_valid = 1'b1;
            end
            S_START: begin
                raw_data  = FLAG_OPEN;
                raw_valid = 1'b1;
            end
            S_PAYLOAD: begin
                raw_data   = in_data;
                raw_valid  = in_valid;
                raw_esc_en = 1'b1;
            end
            S_CRC_LO: begin
                raw_data   = ~fcs[7:0];
                raw_valid  = 1'b1;
                raw_esc_en = 1'b1;
            end
            S_CRC_HI: begin
                raw_data   = ~fcs[15:8];
                raw_valid  = 1'b1;
                raw_esc_en = 1'b1;
            end
            S_STOP: begin
                raw_data  = FLAG_CLOSE;
                raw_valid = 1'b1;
            end
            default: raw_valid = 1'b0;
        endcase
    end

    // Handshake outputs
    always_comb begin
        in_ready   = (state == S_PAYLOAD) && raw_ready;
        busy       = (state != S_IDLE);
        frame_done = (state == S_STOP) && fire;
    end

    sir_fcs16 u_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state == S_IDLE),
        .update ((state == S_PAYLOAD) && fire),
        .din    (in_data),
        .fcs    (fcs)
    );

    sir_escaper u_esc (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_data   (raw_data),
        .raw_valid  (raw_valid),
        .raw_esc_en (raw_esc_en),
        .raw_ready  (raw_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready)
    );

    // R4: the check register starts every frame from its preset
    assert_fcs_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START) |-> (fcs == FCS_PRESET));

    // R7: a stalled output byte stays offered and unchanged
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: completion is a single pulse followed by idle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy));

    // R9: payload is pulled only in the payload phase
    assert_pull_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (state == S_PAYLOAD));

    // R5: flag bytes leave untouched, never as an escape
    assert_flags_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (state == S_PREAMBLE || state == S_START || state == S_STOP))
            |-> (out_data != ESC_CHAR));

    // R8: a request right after completion always gets extra flags
    assert_b2b_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && just_ended && sof_req) |=> (state == S_PREAMBLE));

endmodule

// File: tb/sim_sir_tx_framer.sv
module sim_sir_tx_framer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sof_req;
    logic [CNT_W-1:0] flag_cnt;
    logic             extra_ff;
    logic [7:0]       in_data;
    logic             in_valid;
    logic             in_last;
    logic             in_ready;
    logic [7:0]       out_data;
    logic             out_valid;
    logic             out_ready;
    logic             busy;
    logic             frame_done;

    int checks = 0;
    int errors = 0;
    int ready_pct = 100;
    int cycles = 0;

    logic [7:0] pay_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    logic       prev_stall = 1'b0;
    logic [7:0] prev_data  = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sir_tx_framer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sof_req(sof_req), .flag_cnt(flag_cnt),
        .extra_ff(extra_ff), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
        .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit reserved(input logic [7:0] b);
        return b == 8'hC0 || b == 8'hC1 || b == 8'h7D;
    endfunction

    function automatic logic [15:0] model_fcs();
        logic [15:0] c = 16'hFFFF;
        foreach (pay_q[k]) begin
            c = c ^ {8'h00, pay_q[k]};
            for (int j = 0; j < 8; j++) begin
                if (c[0]) c = (c >> 1) ^ 16'h8408;
                else      c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic push_body(input logic [7:0] b, input string req);
        if (reserved(b)) begin
            exp_q.push_back(8'h7D);           tag_q.push_back(req);
            exp_q.push_back(b ^ 8'h20);       tag_q.push_back(req);
        end else begin
            exp_q.push_back(b);               tag_q.push_back(req);
        end
    endtask

    task automatic build_expected(input int nflags, input bit ff, input string freq);
        logic [15:0] f;
        exp_q.delete();
        tag_q.delete();
        for (int k = 0; k < nflags - 1; k++) begin
            exp_q.push_back(ff ? 8'hFF : 8'hC0); tag_q.push_back(freq);
        end
        exp_q.push_back(8'hC0); tag_q.push_back(freq);
        foreach (pay_q[k]) push_body(pay_q[k], "R3");
        f = model_fcs();
        push_body(f[7:0],  "R4/R5");
        push_body(f[15:8], "R4/R5");
        exp_q.push_back(8'hC1); tag_q.push_back("R6");
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            if (prev_stall) begin
                check(out_valid && out_data == prev_data, "R7", "stalled byte held",
                      {out_valid, out_data}, {1'b1, prev_data});
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (in_ready) begin
                check(busy, "R9", "in_ready outside a frame", busy, 1);
            end
            if (frame_done) begin
                check(out_valid && out_ready && out_data == 8'hC1, "R6",
                      "done without stop flag", out_data, 8'hC1);
            end
        end
    end

    // Random serializer back-pressure
    initial begin
        out_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            out_ready = (int'($urandom % 100) < ready_pct);
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_frame(input int fc, input bit ff, input bit b2b);
        int eff;
        string freq;
        eff = (fc == 0) ? 1 : fc;
        freq = "R2";
        if (b2b && eff < 2) begin
            eff = 2;
            freq = "R8";
        end
        if (!b2b) begin
            repeat (2) @(posedge clk);
            #1;
        end
        build_expected(eff, ff, freq);
        got_q.delete();
        flag_cnt = CNT_W'(fc);
        extra_ff = ff;
        sof_req  = 1'b1;
        do begin
            @(posedge clk);
            #1;
        end while (!busy);
        // R9: disturb the configuration and keep requesting mid-frame
        flag_cnt = CNT_W'($urandom);
        extra_ff = ~ff;
        foreach (pay_q[k]) begin
            if ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                in_data  = 8'hC0;
                repeat (1 + $urandom % 3) @(posedge clk);
                #1;
            end
            in_valid = 1'b1;
            in_data  = pay_q[k];
            in_last  = (k == pay_q.size() - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        sof_req  = 1'b0;
        forever begin
            @(negedge clk);
            if (frame_done) break;
        end
        @(posedge clk);
        #1;
        check(!busy, "R6", "busy after done", busy, 0);
        check(got_q.size() == exp_q.size(), "R3", "frame length",
              got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size()) begin
            foreach (exp_q[k]) begin
                check(got_q[k] == exp_q[k], tag_q[k], $sformatf("byte %0d", k),
                      got_q[k], exp_q[k]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n    = 1'b0;
        sof_req  = 1'b0;
        flag_cnt = '0;
        extra_ff = 1'b0;
        in_data  = 8'h00;
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && !in_ready && !busy && !frame_done, "R1", "during reset",
              {out_valid, in_ready, busy, frame_done}, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !in_ready && !busy && !frame_done, "R1", "after reset",
              {out_valid, in_ready, busy, frame_done}, 0);

        // Known check vector: "123456789"
        pay_q.delete();
        for (int k = 0; k < 9; k++) pay_q.push_back(8'h31 + 8'(k));
        run_frame(1, 1'b0, 1'b0);
        if (got_q.size() >= 3) begin
            check(got_q[got_q.size()-3] == 8'h6E && got_q[got_q.size()-2] == 8'h90,
                  "R4", "check vector", {got_q[got_q.size()-3], got_q[got_q.size()-2]},
                  16'h6E90);
        end

        // All reserved values, single flag with count 0
        pay_q = '{8'hC0, 8'hC1, 8'h7D, 8'h7D};
        run_frame(0, 1'b1, 1'b0);

        // Single-byte frame, then two back-to-back frames with short counts
        pay_q = '{8'h5A};
        run_frame(3, 1'b1, 1'b0);
        pay_q = '{8'hC1, 8'h00};
        run_frame(1, 1'b1, 1'b1);
        pay_q = '{8'h7D};
        run_frame(0, 1'b0, 1'b1);
        pay_q = '{8'h11, 8'h22};
        run_frame(5, 1'b0, 1'b1);

        // Random frames under back-pressure
        for (int f = 0; f < 60; f++) begin
            int len;
            ready_pct = (f % 3 == 0) ? 100 : 40 + int'($urandom % 50);
            len = 1 + int'($urandom % 12);
            pay_q.delete();
            for (int k = 0; k < len; k++) begin
                case ($urandom % 6)
                    0: pay_q.push_back(8'hC0);
                    1: pay_q.push_back(8'hC1);
                    2: pay_q.push_back(8'h7D);
                    default: pay_q.push_back(8'($urandom));
                endcase
            end
            run_frame(int'($urandom % 6), 1'($urandom), (f % 4 == 1));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule